// File: doc/BRIEF.md
# Two-Way Cache Lookup with Per-Set Way Prediction

This block is the lookup stage of a small two-way set-associative cache. Each set keeps one bit that guesses which way holds the requested line. On the first probe cycle, only that way's tag is compared and its line already drives the data mux. A correct guess finishes at once. A wrong guess costs one more cycle, in which the other way is compared. A hit found there retrains the bit so that it points at that way.

When neither way matches, the block asks the next level for the whole line. It keeps the line address steady until the line comes back. It then installs the line in a free way, or, if both ways are full, in the way that was not predicted. The predictor is then set to point at the new line. Writes allocate on a miss and update the word in place on a hit. There is no write-back. The unit handles one request at a time.

Top module: `wp_cache`

## Requirements
- R1: Reset clears every valid bit and sets every set's predictor to way 0. After reset, `req_ready` is 1 and `rsp_done`, `fill_req` and `probe_en` are 0. The first access to any address after reset is a miss.
- R2: In the first probe cycle, `probe_en` is one-hot on the predicted way (bit 0 = way 0, bit 1 = way 1). In the second probe cycle it is one-hot on the other way. It is 0 in every other state.
- R3: A request accepted at a clock edge while `req_ready` is 1 that hits in the predicted way raises `rsp_done` with `rsp_hit`=1 two edges after acceptance.
- R4: A hit in the non-predicted way raises `rsp_done` with `rsp_hit`=1 three edges after acceptance. It also sets that set's predictor to the way that hit.
- R5: When both ways miss, `fill_req` rises and `fill_addr` carries the address without its word-offset bits. Both stay steady until `fill_valid` is sampled. At that edge, `rsp_done` rises with `rsp_hit`=0 and `rsp_rdata` carries the requested word of `fill_line`. Word w of `fill_line` sits at bits [w*DW +: DW].
- R6: The refilled line goes into way 0 if way 0 is invalid, else into way 1 if way 1 is invalid, else into the way the predictor did not name.
- R7: After a refill, the set's predictor names the way just filled.
- R8: A write replaces one word: the word in the matching way on a hit, or the word in the installed line on a miss. The write response returns the written word on `rsp_rdata`. Predictor rules are the same as for reads.
- R9: `rsp_done` is high for exactly one cycle per request. `req_valid` is ignored while `req_ready` is 0 and does not change any stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_ready | output | 1 | Unit is idle and will accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address {tag, set index, word offset} |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_hit | output | 1 | Request hit in either way |
| rsp_rdata | output | DW | Read word, or the written word for writes |
| fill_req | output | 1 | Line wanted from next level |
| fill_addr | output | AW-log2(WORDS) | Line address of the missing line |
| fill_valid | input | 1 | Returned line is present on fill_line |
| fill_line | input | WORDS*DW | Returned line, word w at bits [w*DW +: DW] |
| probe_en | output | 2 | Per-way tag enable for the current probe |

## Verification
The bench builds the block with four sets, two 8-bit words per line and 8-bit addresses. With so few sets, three distinct tags in one set force an eviction within a handful of requests. The bench traces the predictor through fast hits, slow hits with retraining, and refills into an empty way and into a full set, and confirms the chosen victim by which line survives. Its backing store returns each word as the address XOR 0xA5. That makes every returned word, and every merged write, distinguishable.

// File: rtl/wp_cache.sv
module wp_cache #(
  parameter int SETS  = 4,
  parameter int WORDS = 2,
  parameter int DW    = 8,
  parameter int AW    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_write,
  input  logic [AW-1:0]                  req_addr,
  input  logic [DW-1:0]                  req_wdata,
  output logic                           rsp_done,
  output logic                           rsp_hit,
  output logic [DW-1:0]                  rsp_rdata,
  output logic                           fill_req,
  output logic [AW-$clog2(WORDS)-1:0]    fill_addr,
  input  logic                           fill_valid,
  input  logic [WORDS*DW-1:0]            fill_line,
  output logic [1:0]                     probe_en
);
  localparam int OB = $clog2(WORDS);
  localparam int IB = $clog2(SETS);
  localparam int TW = AW - OB - IB;
  localparam int LW = WORDS * DW;

  typedef enum logic [1:0] {IDLE, FIRST, SECOND, FILL} st_t;
  st_t st;

  logic [AW-1:0] a_q;
  logic          w_q;
  logic [DW-1:0] wd_q;

  logic [TW-1:0]   tag_m [SETS][2];
  logic [LW-1:0]   dat_m [SETS][2];
  logic [1:0]      vld_m [SETS];
  logic [SETS-1:0] pred_m;

  logic [IB-1:0] idx;
  logic [TW-1:0] tg;
  logic [OB-1:0] off;
  logic          pw, way, match, victim;
  logic [LW-1:0] base, merged;

  assign idx   = a_q[OB +: IB];
  assign tg    = a_q[AW-1 -: TW];
  assign off   = a_q[OB-1:0];
  assign pw    = pred_m[idx];
  assign way   = (st == SECOND) ? ~pw : pw;
  assign match = vld_m[idx][way] && (tag_m[idx][way] == tg);
  assign victim = !vld_m[idx][0] ? 1'b0 : (!vld_m[idx][1] ? 1'b1 : ~pw);

  assign base = (st == FILL) ? fill_line : dat_m[idx][way];

  always_comb begin
    merged = base;
    if (w_q) merged[off*DW +: DW] = wd_q;
  end

  assign req_ready = (st == IDLE);
  assign fill_req  = (st == FILL);
  assign fill_addr = a_q[AW-1:OB];
  assign probe_en  = (st == FIRST || st == SECOND) ? (way ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      rsp_done  <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
      a_q       <= '0;
      w_q       <= 1'b0;
      wd_q      <= '0;
      pred_m    <= '0;
      for (int s = 0; s < SETS; s++) vld_m[s] <= 2'b00;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          a_q  <= req_addr;
          w_q  <= req_write;
          wd_q <= req_wdata;
          st   <= FIRST;
        end
        FIRST, SECOND: begin
          if (match) begin
            rsp_done    <= 1'b1;
            rsp_hit     <= 1'b1;
            rsp_rdata   <= merged[off*DW +: DW];
            pred_m[idx] <= way;
            if (w_q) dat_m[idx][way] <= merged;
            st <= IDLE;
          end else begin
            st <= (st == FIRST) ? SECOND : FILL;
          end
        end
        FILL: if (fill_valid) begin
          dat_m[idx][victim] <= merged;
          tag_m[idx][victim] <= tg;
          vld_m[idx][victim] <= 1'b1;
          pred_m[idx]        <= victim;
          rsp_done  <= 1'b1;
          rsp_hit   <= 1'b0;
          rsp_rdata <= merged[off*DW +: DW];
          st        <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wp_cache_chk.sv
module wp_cache_chk #(
  parameter int WORDS = 2,
  parameter int AW    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_ready,
  input logic                        rsp_done,
  input logic                        rsp_hit,
  input logic                        fill_req,
  input logic [AW-$clog2(WORDS)-1:0] fill_addr,
  input logic                        fill_valid,
  input logic [1:0]                  probe_en
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  // R2
  probe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_en));

  // R2
  probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || fill_req) |-> (probe_en == 2'b00));

  // R5
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

  // R3
  hit_after_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_en != 2'b00) |=> (!rsp_done || rsp_hit));
endmodule

bind wp_cache wp_cache_chk #(.WORDS(WORDS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .rsp_hit(rsp_hit), .fill_req(fill_req), .fill_addr(fill_addr),
  .fill_valid(fill_valid), .probe_en(probe_en)
);

// File: tb/wp_cache_test.sv
module wp_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 4, WORDS = 2, DW = 8, AW = 8;

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] wd;
    logic       hit;
    logic [3:0] lat;
    logic [7:0] rd;
    logic [1:0] probe;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{1'b0, 8'h0A, 8'h00, 1'b0, 4'd4, 8'hAF, 2'b01},
    '{1'b0, 8'h0B, 8'h00, 1'b1, 4'd2, 8'hAE, 2'b01},
    '{1'b0, 8'h12, 8'h00, 1'b0, 4'd4, 8'hB7, 2'b01},
    '{1'b0, 8'h0A, 8'h00, 1'b1, 4'd3, 8'hAF, 2'b10},
    '{1'b0, 8'h0A, 8'h00, 1'b1, 4'd2, 8'hAF, 2'b01},
    '{1'b0, 8'h13, 8'h00, 1'b1, 4'd3, 8'hB6, 2'b01},
    '{1'b0, 8'h1A, 8'h00, 1'b0, 4'd4, 8'hBF, 2'b10},
    '{1'b0, 8'h12, 8'h00, 1'b1, 4'd3, 8'hB7, 2'b01},
    '{1'b0, 8'h0A, 8'h00, 1'b0, 4'd4, 8'hAF, 2'b10},
    '{1'b1, 8'h13, 8'h3C, 1'b1, 4'd3, 8'h3C, 2'b01},
    '{1'b0, 8'h13, 8'h00, 1'b1, 4'd2, 8'h3C, 2'b10},
    '{1'b1, 8'h25, 8'h77, 1'b0, 4'd4, 8'h77, 2'b01},
    '{1'b0, 8'h25, 8'h00, 1'b1, 4'd2, 8'h77, 2'b01},
    '{1'b0, 8'h24, 8'h00, 1'b1, 4'd2, 8'h81, 2'b01},
    '{1'b0, 8'h00, 8'h00, 1'b0, 4'd4, 8'hA5, 2'b01}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, fill_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [WORDS*DW-1:0] fill_line = '0;
  logic req_ready, rsp_done, rsp_hit, fill_req;
  logic [DW-1:0] rsp_rdata;
  logic [AW-2:0] fill_addr;
  logic [1:0] probe_en;

  int nchk = 0, nerr = 0;
  int g_lat;
  logic g_hit, g_fill;
  logic [7:0] g_rd;
  logic [1:0] g_probe;
  logic [AW-2:0] g_fa;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_cache #(.SETS(SETS), .WORDS(WORDS), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
    .fill_line(fill_line), .probe_en(probe_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        input bit spoil);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    g_fill = 1'b0; g_fa = '0;
    @(negedge clk);
    req_valid = 1'b0;
    g_lat = 1; g_probe = probe_en;
    while (!rsp_done && g_lat < 40) begin
      if (fill_req) begin
        g_fill = 1'b1; g_fa = fill_addr;
        fill_valid = 1'b1;
        fill_line = {fill_addr, 1'b1} ^ 8'hA5;
        fill_line = {8'({fill_addr, 1'b1}) ^ 8'hA5, 8'({fill_addr, 1'b0}) ^ 8'hA5};
        if (spoil) begin
          req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h24; req_wdata = 8'hEE;
        end
      end
      @(negedge clk);
      fill_valid = 1'b0; req_valid = 1'b0;
      g_lat++;
    end
    g_hit = rsp_hit; g_rd = rsp_rdata;
    @(negedge clk);
    chk("R9 done one cycle", rsp_done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", req_ready, 1);
    chk("R1 done", rsp_done, 0);
    chk("R1 fill_req", fill_req, 0);
    chk("R1 probe_en", probe_en, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 15; i++) begin
      do_req(VEC[i].wr, VEC[i].addr, VEC[i].wd, 1'b0);
      // R3 R4 R5 latency; R2 first probe; R6 R7 R8 via hit/data outcomes
      chk($sformatf("R2 probe v%0d", i), g_probe, VEC[i].probe);
      chk($sformatf("R3/R4/R5 latency v%0d", i), g_lat, VEC[i].lat);
      chk($sformatf("R6/R7 hit v%0d", i), g_hit, VEC[i].hit);
      chk($sformatf("R8 data v%0d", i), g_rd, VEC[i].rd);
      if (!VEC[i].hit) chk($sformatf("R5 fill_addr v%0d", i), g_fa, VEC[i].addr >> 1);
    end

    // R9: write to 0x24 offered while refilling 0x34 must be ignored
    do_req(1'b0, 8'h34, 8'h00, 1'b1);
    chk("R5 miss 0x34", g_hit, 0);
    chk("R5 data 0x34", g_rd, 8'h91);
    do_req(1'b0, 8'h24, 8'h00, 1'b0);
    chk("R6 victim way1 probe", g_probe, 2'b10);
    chk("R4 slow latency", g_lat, 3);
    chk("R9 ignored write", g_rd, 8'h81);

    // R1 reset mid-stream invalidates lines
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 ready again", req_ready, 1);
    chk("R1 probe again", probe_en, 0);
    rst_n = 1'b1;
    do_req(1'b0, 8'h24, 8'h00, 1'b0);
    chk("R1 cold miss", g_hit, 0);
    chk("R1 cold latency", g_lat, 4);
    chk("R1 predictor way0", g_probe, 2'b01);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule